// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the external bus cycles of a 16-bit embedded processor whose address and data share one set of AD lines. A cycle request (address, write data, byte or word size, direction, refresh flag and chip-select region) is accepted while the sequencer is idle. The sequencer then steps through the phases T1, T2, T3, any number of wait phases TW, and T4. It drives the byte-high-enable line and the AD lanes as the phase requires, and it captures read data at the clock where the cycle becomes ready.

Wait phases follow a ready condition that combines an asynchronous ready, passed through a synchronizer, with a synchronous ready. The address phase may be left undriven for cycles to the upper or lower chip-select region when that region's address-disable bit is set. The address-enable strap is captured during reset and, when low, overrides both address-disable bits. DRAM refresh cycles carry a dedicated lane code and an all-ones address. A hold request floats the bus, but only between cycles.

Top module: `adbus_seq`

## Requirements
- R1: In T1 the lane code is bhe_n=0 with AD0=0 for a word, bhe_n=0 with AD0=1 for a byte at an odd address (bits 15:8), and bhe_n=1 with AD0=0 for a byte at an even address (bits 7:0). The other AD bits carry req_addr[15:1], and a word always drives AD0 as 0.
- R2: A refresh cycle drives bhe_n=1 and ad_out=FFFFh on both lanes in T1, releases AD from T2 through T4, and produces no rd_valid.
- R3: bhe_oe is 1 and bhe_n keeps its T1 value through T2, T3, every TW and T4 of the same cycle.
- R4: While rst is high or hold_ack is high, bhe_oe=0 and ad_oe=2'b00.
- R5: With the latched strap high, a non-refresh cycle whose req_region is 1 (upper) with da_upper=1, or 2 (lower) with da_lower=1, drives ad_oe=2'b00 in T1. Every other T1 drives ad_oe=2'b11.
- R6: addr_en_strap is captured on every clock while rst is high, and the value held at reset release is kept until the next reset. With a captured 0, every T1 drives its address regardless of da_upper and da_lower.
- R7: A byte access at an even address drives req_addr[15:8] on AD[15:8] (ad_oe[1]=1) from T2 through T4, for both reads and writes and regardless of the address-disable bits.
- R8: ardy passes through SYNC_STAGES flip-flops before use. The combined ready is that synchronized value OR srdy. ardy held high gives zero wait phases. ardy rising in T3 with srdy low gives exactly SYNC_STAGES wait phases.
- R9: The cycle moves from T3 or TW to T4 only on a clock edge where the combined ready is high. Every other edge from T3 or TW enters TW.
- R10: A write drives data from T2 through T4. A word uses ad_oe=2'b11 with req_wdata. A byte at an even address puts req_wdata[7:0] on bits 7:0. A byte at an odd address uses ad_oe=2'b10 with req_wdata[7:0] on bits 15:8.
- R11: A non-refresh read releases its data lanes after T1. It captures ad_in into rd_data on the edge that leaves the last T3 or TW, and raises rd_valid for exactly the T4 clock.
- R12: req_ready is high only in idle with hold_req low. hold_ack rises only out of idle and never during T1 through T4. After hold_req falls, the sequencer returns to idle.
- R13: phase reports 0 for idle, 1 for T1, 2 for T2, 3 for T3, 4 for TW, 5 for T4 and 6 for hold. An accepted request gives T1 on the next clock, and T4 is followed by idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_en_strap | input | 1 | Address-enable strap, captured during reset |
| da_upper | input | 1 | Address-disable bit of the upper region |
| da_lower | input | 1 | Address-disable bit of the lower region |
| req_valid | input | 1 | Cycle request present |
| req_ready | output | 1 | Request accepted this clock |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 16 | Write data |
| req_byte | input | 1 | 1 for a byte access, 0 for a word |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_refresh | input | 1 | Refresh cycle |
| req_region | input | 2 | 0 other, 1 upper, 2 lower chip-select region |
| ardy | input | 1 | Asynchronous ready, active high |
| srdy | input | 1 | Synchronous ready, active high |
| hold_req | input | 1 | Bus hold request |
| hold_ack | output | 1 | Bus hold granted |
| phase | output | 3 | Current bus phase |
| bhe_n | output | 1 | Byte-high enable, active low |
| bhe_oe | output | 1 | Output enable of bhe_n |
| ad_out | output | 16 | AD lines driven value |
| ad_oe | output | 2 | Per-lane output enable, bit 1 for 15:8 |
| ad_in | input | 16 | AD lines sampled value |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | rd_data updated, one clock |

## Verification
The bench sweeps every combination of size, address parity, direction, region, both address-disable bits and zero to two wait phases, under both strap values. In each phase it compares the lane code, the per-lane enables and the enabled AD bits. A design that mixed up the high-byte and low-byte codes, or forgot the address on the upper lane for even-byte accesses, fails in T1 or T2. A design that let the address-disable bits act while the strap reads low, or that re-read the strap after reset, drives or suppresses the wrong T1. The bench also raises ardy in T3 to confirm the synchronizer delay costs exactly two wait phases. It requests hold in the middle of a cycle: a design that grants hold early floats the bus before T4.

// File: rtl/adbus_pkg.sv
package adbus_pkg;

    localparam int unsigned AD_W   = 16;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = AD_W / LANE_W;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5,
        PH_HOLD = 3'd6
    } phase_e;

    typedef enum logic [1:0] {
        RGN_OTHER = 2'd0,
        RGN_UPPER = 2'd1,
        RGN_LOWER = 2'd2
    } region_e;

    typedef struct packed {
        logic [AD_W-1:0] addr;
        logic [AD_W-1:0] wdata;
        logic            byte_sz;
        logic            write;
        logic            refresh;
        region_e         region;
    } busreq_t;

    // Lane code: active-low high enable; refresh forces it high.
    function automatic logic lane_bhe_n(busreq_t r);
        return r.refresh | (r.byte_sz & ~r.addr[0]);
    endfunction

    // AD0 in the address phase: words are forced even.
    function automatic logic lane_ad0(busreq_t r);
        return r.refresh | (r.byte_sz & r.addr[0]);
    endfunction

    function automatic logic in_cycle(phase_e p);
        return (p == PH_T1) || (p == PH_T2) || (p == PH_T3) ||
               (p == PH_TW) || (p == PH_T4);
    endfunction

endpackage

// File: rtl/adbus_rdy_sync.sv
module adbus_rdy_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/adbus_fsm.sv
module adbus_fsm
    import adbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    strap,
    input  logic    req_valid,
    input  busreq_t req_in,
    input  logic    rdy,
    input  logic    hold_req,
    output phase_e  phase,
    output busreq_t cur,
    output logic    strap_q,
    output logic    req_ready,
    output logic    cap
);
    phase_e nxt;

    assign req_ready = (phase == PH_IDLE) && !hold_req;
    assign cap = ((phase == PH_T3) || (phase == PH_TW)) && rdy &&
                 !cur.write && !cur.refresh;

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE: begin
                if (hold_req)       nxt = PH_HOLD;
                else if (req_valid) nxt = PH_T1;
            end
            PH_HOLD: if (!hold_req) nxt = PH_IDLE;
            PH_T1:   nxt = PH_T2;
            PH_T2:   nxt = PH_T3;
            PH_T3, PH_TW: nxt = rdy ? PH_T4 : PH_TW;
            PH_T4:   nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            strap_q <= strap;
            cur     <= '0;
        end else begin
            phase <= nxt;
            if (req_ready && req_valid) cur <= req_in;
        end
    end
endmodule

// File: rtl/adbus_lane_drv.sv
module adbus_lane_drv
    import adbus_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  phase_e                phase,
    input  busreq_t               cur,
    input  logic                  strap_q,
    input  logic                  da_upper,
    input  logic                  da_lower,
    input  logic                  cap,
    input  logic [AD_W-1:0]       ad_in,
    output logic                  bhe_n,
    output logic                  bhe_oe,
    output logic [AD_W-1:0]       ad_out,
    output logic [LANES-1:0]      ad_oe,
    output logic [AD_W-1:0]       rd_data,
    output logic                  rd_valid
);
    logic             suppress;
    logic [AD_W-1:0]  t1_val;
    logic [AD_W-1:0]  dval;
    logic [LANES-1:0] doe;

    assign suppress = strap_q && !cur.refresh &&
                      (((cur.region == RGN_UPPER) && da_upper) ||
                       ((cur.region == RGN_LOWER) && da_lower));

    assign t1_val = cur.refresh ? {AD_W{1'b1}}
                                : {cur.addr[AD_W-1:1], lane_ad0(cur)};

    // Data-phase lane plan
    always_comb begin
        dval = '0;
        doe  = '0;
        if (!cur.refresh) begin
            if (!cur.byte_sz) begin
                if (cur.write) begin
                    dval = cur.wdata;
                    doe  = '1;
                end
            end else if (!cur.addr[0]) begin
                dval = {cur.addr[AD_W-1:LANE_W], cur.wdata[LANE_W-1:0]};
                doe  = {1'b1, cur.write};
            end else if (cur.write) begin
                dval = {cur.wdata[LANE_W-1:0], {LANE_W{1'b0}}};
                doe  = {1'b1, 1'b0};
            end
        end
    end

    always_comb begin
        ad_out = '0;
        ad_oe  = '0;
        if (!rst) begin
            if (phase == PH_T1) begin
                ad_out = t1_val;
                ad_oe  = suppress ? '0 : '1;
            end else if (in_cycle(phase)) begin
                ad_out = dval;
                ad_oe  = doe;
            end
        end
    end

    assign bhe_oe = !rst && (phase != PH_HOLD);
    assign bhe_n  = in_cycle(phase) ? lane_bhe_n(cur) : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cap;
            if (cap) rd_data <= ad_in;
        end
    end
endmodule

// File: rtl/adbus_seq.sv
module adbus_seq
    import adbus_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_en_strap,
    input  logic              da_upper,
    input  logic              da_lower,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_addr,
    input  logic [15:0]       req_wdata,
    input  logic              req_byte,
    input  logic              req_write,
    input  logic              req_refresh,
    input  logic [1:0]        req_region,
    input  logic              ardy,
    input  logic              srdy,
    input  logic              hold_req,
    output logic              hold_ack,
    output logic [2:0]        phase,
    output logic              bhe_n,
    output logic              bhe_oe,
    output logic [15:0]       ad_out,
    output logic [1:0]        ad_oe,
    input  logic [15:0]       ad_in,
    output logic [15:0]       rd_data,
    output logic              rd_valid
);
    logic    ardy_s;
    logic    rdy;
    logic    strap_q;
    logic    cap;
    phase_e  ph;
    busreq_t req_in;
    busreq_t cur;

    assign req_in = '{addr: req_addr, wdata: req_wdata, byte_sz: req_byte,
                      write: req_write, refresh: req_refresh,
                      region: region_e'(req_region)};

    adbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(ardy), .q(ardy_s)
    );

    assign rdy = ardy_s | srdy;

    adbus_fsm u_fsm (
        .clk(clk), .rst(rst), .strap(addr_en_strap),
        .req_valid(req_valid), .req_in(req_in), .rdy(rdy),
        .hold_req(hold_req), .phase(ph), .cur(cur), .strap_q(strap_q),
        .req_ready(req_ready), .cap(cap)
    );

    adbus_lane_drv u_lane (
        .clk(clk), .rst(rst), .phase(ph), .cur(cur), .strap_q(strap_q),
        .da_upper(da_upper), .da_lower(da_lower), .cap(cap), .ad_in(ad_in),
        .bhe_n(bhe_n), .bhe_oe(bhe_oe), .ad_out(ad_out), .ad_oe(ad_oe),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign phase    = ph;
    assign hold_ack = (ph == PH_HOLD);
endmodule

// File: rtl/adbus_seq_chk.sv
module adbus_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  phase,
    input logic        hold_ack,
    input logic        bhe_n,
    input logic        bhe_oe,
    input logic [15:0] ad_out,
    input logic [1:0]  ad_oe,
    input logic        rd_valid,
    input logic        ardy_s,
    input logic        srdy
);
    logic in_wait;
    logic mid;
    logic data_ph;
    assign in_wait = (phase == 3'd3) || (phase == 3'd4);
    assign mid     = (phase >= 3'd1) && (phase <= 3'd4);
    assign data_ph = (phase >= 3'd2) && (phase <= 3'd5);

    assert_float_reset_R4: assert property (@(posedge clk)
        rst |-> (!bhe_oe && ad_oe == 2'b00));

    assert_float_hold_R4: assert property (@(posedge clk) disable iff (rst)
        hold_ack |-> (!bhe_oe && ad_oe == 2'b00));

    assert_no_hold_midcycle_R12: assert property (@(posedge clk) disable iff (rst)
        mid |=> !hold_ack);

    assert_bhe_steady_R3: assert property (@(posedge clk) disable iff (rst)
        data_ph |-> (bhe_oe && $stable(bhe_n)));

    assert_wait_inserted_R9: assert property (@(posedge clk) disable iff (rst)
        (in_wait && !(ardy_s || srdy)) |=> (phase == 3'd4));

    assert_exit_on_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (in_wait && (ardy_s || srdy)) |=> (phase == 3'd5));

    assert_refresh_ones_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd1 && bhe_n && ad_oe == 2'b11 && ad_out[0]) |-> (ad_out == 16'hFFFF));

    assert_rd_valid_t4_R11: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (phase == 3'd5));
endmodule

bind adbus_seq adbus_seq_chk u_chk (
    .clk(clk), .rst(rst), .phase(phase), .hold_ack(hold_ack),
    .bhe_n(bhe_n), .bhe_oe(bhe_oe), .ad_out(ad_out), .ad_oe(ad_oe),
    .rd_valid(rd_valid), .ardy_s(ardy_s), .srdy(srdy)
);

// File: tb/sim_adbus_seq.sv
module sim_adbus_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_en_strap = 1'b1;
    logic        da_upper = 1'b0, da_lower = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        req_byte = 1'b0, req_write = 1'b0, req_refresh = 1'b0;
    logic [1:0]  req_region = '0;
    logic        ardy = 1'b0, srdy = 1'b0, hold_req = 1'b0, hold_ack;
    logic [2:0]  phase;
    logic        bhe_n, bhe_oe, rd_valid;
    logic [15:0] ad_out, ad_in = '0, rd_data;
    logic [1:0]  ad_oe;

    int checks = 0;
    int errors = 0;
    bit strap_now;

    always #(CLK_PERIOD/2) clk = ~clk;

    adbus_seq u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input bit strap);
        rst = 1'b1;
        addr_en_strap = strap;
        tick();
        chk("R4 bhe_oe in reset", bhe_oe, 0);
        chk("R4 ad_oe in reset", ad_oe, 0);
        tick();
        rst = 1'b0;
        strap_now = strap;
        tick();
        chk("R13 idle after reset", phase, 0);
        chk("R12 ready in idle", req_ready, 1);
    endtask

    function automatic logic [15:0] lanemask(input logic [1:0] oe);
        return {{8{oe[1]}}, {8{oe[0]}}};
    endfunction

    task automatic check_bus(input string tag, input logic [1:0] eoe, input logic [15:0] eval);
        chk({tag, " oe"}, ad_oe, eoe);
        chk({tag, " ad"}, ad_out & lanemask(eoe), eval & lanemask(eoe));
    endtask

    // amode 0: ardy low, srdy after nwait waits; 1: ardy held high; 2: ardy rises in T3
    task automatic cyc(input logic [15:0] a, input logic [15:0] wd, input bit bsz,
                       input bit wr, input bit rf, input int rg, input bit du,
                       input bit dl, input int nwait, input int amode);
        logic        ebhe;
        logic [15:0] et1, edv, rdp;
        logic [1:0]  et1oe, edoe;
        bit          sup;
        int          expw, w;
        ebhe = rf | (bsz & ~a[0]);
        et1  = rf ? 16'hFFFF : {a[15:1], (bsz ? a[0] : 1'b0)};
        sup  = strap_now && !rf && ((rg == 1 && du) || (rg == 2 && dl));
        et1oe = sup ? 2'b00 : 2'b11;
        edoe = 2'b00; edv = '0;
        if (!rf) begin
            if (!bsz) begin
                if (wr) begin edoe = 2'b11; edv = wd; end
            end else if (!a[0]) begin
                edoe = {1'b1, wr}; edv = {a[15:8], wd[7:0]};
            end else if (wr) begin
                edoe = 2'b10; edv = {wd[7:0], 8'h00};
            end
        end
        rdp  = ~a ^ {wd[7:0], wd[15:8]};
        expw = (amode == 1) ? 0 : (amode == 2) ? 2 : nwait;

        da_upper = du; da_lower = dl;
        req_addr = a; req_wdata = wd; req_byte = bsz; req_write = wr;
        req_refresh = rf; req_region = 2'(rg); req_valid = 1'b1;
        srdy = 1'b0;
        ardy = (amode == 1);
        chk("R12 req_ready before accept", req_ready, 1);
        tick();
        req_valid = 1'b0;
        req_addr = ~a; req_wdata = ~wd;   // later changes must not matter
        ad_in = rdp;
        chk("R13 phase T1", phase, 1);
        chk("R1 bhe_n in T1", bhe_n, ebhe);
        chk("R3 bhe_oe in T1", bhe_oe, 1);
        check_bus(rf ? "R2 refresh T1" : (sup ? "R5 suppressed T1" : "R1 R6 address T1"), et1oe, et1);
        tick();
        chk("R13 phase T2", phase, 2);
        chk("R3 bhe_n in T2", bhe_n, ebhe);
        check_bus(rf ? "R2 refresh T2" : (wr ? "R10 write T2" : "R7 R11 read T2"), edoe, edv);
        tick();
        chk("R13 phase T3", phase, 3);
        check_bus("R10 R11 T3", edoe, edv);
        if (amode == 0) srdy = (nwait == 0);
        if (amode == 2) ardy = 1'b1;
        w = 0;
        for (int k = 0; k < 6; k++) begin
            tick();
            if (phase != 3'd4) break;
            w++;
            chk("R3 bhe_n in TW", bhe_n, ebhe);
            check_bus("R10 R11 TW", edoe, edv);
            if (amode == 0) srdy = (w == nwait);
        end
        srdy = 1'b0;
        chk(amode == 0 ? "R9 wait count" : "R8 wait count", w, expw);
        chk("R13 phase T4", phase, 5);
        chk("R3 bhe_n in T4", bhe_n, ebhe);
        check_bus("R7 R10 T4", edoe, edv);
        chk(rf ? "R2 no rd_valid" : "R11 rd_valid", rd_valid, !wr && !rf);
        if (!wr && !rf) chk("R11 rd_data", rd_data, rdp);
        ardy = 1'b0;
        tick();
        chk("R13 idle after T4", phase, 0);
        chk("R11 rd_valid one clock", rd_valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int s = 1; s >= 0; s--) begin
            do_reset(s[0]);
            for (int rg = 0; rg < 3; rg++)
                for (int d = 0; d < 4; d++)
                    for (int b = 0; b < 2; b++)
                        for (int a0 = 0; a0 < 2; a0++)
                            for (int wr = 0; wr < 2; wr++)
                                for (int nw = 0; nw < 3; nw++)
                                    cyc(16'hA5C2 ^ 16'(rg * 16'h1110) | 16'(a0),
                                        16'h3C96 + 16'(d * 16'h0101), b[0], wr[0], 1'b0,
                                        rg, d[0], d[1], nw, 0);
            // R2: refresh even with address disable set
            cyc(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 1, 1'b1, 1'b1, 1, 0);
        end

        // R6: strap captured at reset stays after it changes
        do_reset(1'b1);
        addr_en_strap = 1'b0;
        cyc(16'h8000, 16'h1234, 1'b0, 1'b0, 1'b0, 2, 1'b0, 1'b1, 0, 0);
        cyc(16'h4002, 16'h5678, 1'b1, 1'b1, 1'b0, 0, 1'b1, 1'b1, 0, 0);

        // R8: asynchronous ready paths
        cyc(16'h1236, 16'hBEEF, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0, 1);
        cyc(16'h1237, 16'hCAFE, 1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b0, 0, 1);
        cyc(16'h2468, 16'h0F0F, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0, 0, 2);
        cyc(16'h2469, 16'hF00F, 1'b1, 1'b0, 1'b0, 2, 1'b0, 1'b0, 0, 2);

        // R12: hold raised mid-cycle is granted only after T4
        req_addr = 16'h0100; req_write = 1'b1; req_byte = 1'b0; req_refresh = 1'b0;
        req_region = 2'd0; req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        hold_req = 1'b1;
        chk("R12 no ack in T1", hold_ack, 0);
        tick();
        chk("R12 no ack in T2", hold_ack, 0);
        srdy = 1'b1;
        tick();
        chk("R12 no ack in T3", hold_ack, 0);
        tick();
        srdy = 1'b0;
        chk("R12 T4 reached", phase, 5);
        chk("R12 no ack in T4", hold_ack, 0);
        tick();
        chk("R12 idle before hold", phase, 0);
        chk("R12 not ready under hold", req_ready, 0);
        req_valid = 1'b1;
        tick();
        chk("R12 ack", hold_ack, 1);
        chk("R4 bhe float in hold", bhe_oe, 0);
        chk("R4 ad float in hold", ad_oe, 0);
        tick();
        chk("R12 request held off", phase, 6);
        req_valid = 1'b0;
        hold_req = 1'b0;
        tick();
        chk("R12 back to idle", phase, 0);
        chk("R12 ready after hold", req_ready, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule